// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional instruction (branch, set-byte or trap on condition) takes its true path. It takes a 6-bit predicate code and the current floating-point status word, and tests the code against the four condition bits of that word: negative, zero, infinity and not-a-number. It returns one true/false answer and a flag for codes outside the legal range. It also returns the status word with its per-instruction exception byte rebuilt, and a trap request when an exception that software has enabled is now pending.

A predicate code splits into three parts. A signaling flag selects a test that is not IEEE-aware; such a test records an unordered-branch exception when a NaN is present. A negation flag folds the code onto its positive partner and inverts the answer. The remaining three bits select one of eight base relations. The unit is combinational up to one output register stage. An evaluation is launched with a one-cycle strobe, and its results appear, valid and held, on the next clock.

Top module: `fpc_cond_eval`

## Requirements
- R1: Any predicate code of 0x20 or above is illegal. It yields illegalPred=1, condTrue=0 and trapReq=0, and statusOut equals statusIn unchanged.
- R2: Status bit 15 is the unordered-branch exception bit. For a legal code it is set only when predicate bit 4 (signaling) is 1 and the NaN condition bit (status bit 24) is 1. Otherwise it is 0.
- R3: When predicate bit 3 is 1, the base code is the low four bits XOR 0xF. The final answer is the inverse of that base code's answer.
- R4: The condition bits are N=status[27], Z=status[26], I=status[25] and NaN=status[24]. The base codes are:
  - 0: false
  - 1: Z
  - 2: not(NaN or Z or N)
  - 3: Z or not(NaN or N)
  - 4: N and not NaN and not Z
  - 5: Z or (N and not NaN)
  - 6: not(NaN or Z)
  - 7: not NaN
- R5: For a legal code, exception bits 14:8 of statusOut are 0. All status bits outside 15:8 pass through unchanged. The infinity bit never affects condTrue.
- R6: For a legal code, trapReq is 1 exactly when the rebuilt exception byte (statusOut[15:8]) ANDed with trapEnable is nonzero.
- R7: resultValid is 1 in the cycle after an evalValid strobe and 0 otherwise. The other outputs hold their values until the next evaluation.
- R8: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evalValid | input | 1 | Starts an evaluation of the current inputs |
| predCode | input | 6 | Conditional predicate code |
| statusIn | input | 32 | Current floating-point status word |
| trapEnable | input | 8 | Enable byte of the exception byte |
| resultValid | output | 1 | Results below belong to the last strobe |
| condTrue | output | 1 | Predicate answer |
| illegalPred | output | 1 | Predicate code out of range |
| trapReq | output | 1 | An enabled exception is pending |
| statusOut | output | 32 | Status word with rebuilt exception byte |

## Verification
On every cycle, the assertions check the following. An illegal code returns the status word untouched. Only the unordered-branch bit can survive in the exception byte, and it tracks the signaling flag and NaN. A trap follows the enabled exceptions. The outputs hold between strobes, and the false and true codes give constant answers. The truth value of each base relation, and the pairing of each negated code with its partner, are shown only by the bench's sweep. That sweep runs every one of the 64 codes against all 16 condition-bit patterns, with varied enable bytes and stale exception bits.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    BASE_FALSE   = 3'd0,
    BASE_EQ      = 3'd1,
    BASE_GT      = 3'd2,
    BASE_GE      = 3'd3,
    BASE_LT      = 3'd4,
    BASE_LE      = 3'd5,
    BASE_GL      = 3'd6,
    BASE_ORDERED = 3'd7
  } baseRel_e;

  typedef struct packed {
    logic     load;
    logic     illegal;
    logic     signaling;
    logic     negate;
    baseRel_e baseCode;
  } evalStrobes_t;
endpackage

// File: rtl/fpc_pred_ctrl.sv
module fpc_pred_ctrl
  import fpc_pkg::*;
#(
  parameter int PRED_W = 6
) (
  input  logic              evalValid,
  input  logic [PRED_W-1:0] predCode,
  output evalStrobes_t      strobes
);
  localparam int SIG_POS = 4;
  localparam int NEG_POS = 3;
  localparam int LEGAL_W = 5;

  logic outOfRange;
  logic [2:0] lowBits;

  assign outOfRange = |predCode[PRED_W-1:LEGAL_W];
  // folding the negated half: low four bits XOR 0xF clears bit 3 and flips 2:0
  assign lowBits = predCode[NEG_POS] ? ~predCode[2:0] : predCode[2:0];

  always_comb begin
    strobes.load      = evalValid;
    strobes.illegal   = outOfRange;
    strobes.signaling = predCode[SIG_POS];
    strobes.negate    = predCode[NEG_POS];
    strobes.baseCode  = baseRel_e'(lowBits);
  end
endmodule

// File: rtl/fpc_pred_datapath.sv
module fpc_pred_datapath
  import fpc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CC_LSB   = 24,
  parameter int EXC_LSB  = 8,
  parameter int EXC_W    = 8,
  parameter int BSUN_POS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  evalStrobes_t      strobes,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [EXC_W-1:0]  trapEnable,
  output logic              resultValid,
  output logic              condTrue,
  output logic              illegalPred,
  output logic              trapReq,
  output logic [DATA_W-1:0] statusOut
);
  localparam int NAN_POS  = CC_LSB;
  localparam int ZERO_POS = CC_LSB + 2;
  localparam int NEG_POS  = CC_LSB + 3;

  logic ccNan, ccZero, ccNeg;
  logic baseTrue, finalTrue, bsunRaise;
  logic [EXC_W-1:0] newExc;
  logic [DATA_W-1:0] newStatus;

  assign ccNan  = statusIn[NAN_POS];
  assign ccZero = statusIn[ZERO_POS];
  assign ccNeg  = statusIn[NEG_POS];

  always_comb begin
    unique case (strobes.baseCode)
      BASE_FALSE:   baseTrue = 1'b0;
      BASE_EQ:      baseTrue = ccZero;
      BASE_GT:      baseTrue = ~(ccNan | ccZero | ccNeg);
      BASE_GE:      baseTrue = ccZero | ~(ccNan | ccNeg);
      BASE_LT:      baseTrue = ccNeg & ~ccNan & ~ccZero;
      BASE_LE:      baseTrue = ccZero | (ccNeg & ~ccNan);
      BASE_GL:      baseTrue = ~(ccNan | ccZero);
      BASE_ORDERED: baseTrue = ~ccNan;
      default:      baseTrue = 1'b0;
    endcase
  end

  assign finalTrue = baseTrue ^ strobes.negate;
  assign bsunRaise = strobes.signaling & ccNan;

  for (genvar b = 0; b < EXC_W; b++) begin : g_exc
    if (b == BSUN_POS) begin : g_bsun
      assign newExc[b] = bsunRaise;
    end else begin : g_clr
      assign newExc[b] = 1'b0;
    end
  end

  always_comb begin
    newStatus = statusIn;
    newStatus[EXC_LSB +: EXC_W] = newExc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      condTrue    <= 1'b0;
      illegalPred <= 1'b0;
      trapReq     <= 1'b0;
      statusOut   <= '0;
    end else begin
      resultValid <= strobes.load;
      if (strobes.load) begin
        illegalPred <= strobes.illegal;
        if (strobes.illegal) begin
          condTrue  <= 1'b0;
          trapReq   <= 1'b0;
          statusOut <= statusIn;
        end else begin
          condTrue  <= finalTrue;
          trapReq   <= |(newExc & trapEnable);
          statusOut <= newStatus;
        end
      end
    end
  end
endmodule

// File: rtl/fpc_cond_eval.sv
module fpc_cond_eval
  import fpc_pkg::*;
#(
  parameter int PRED_W   = 6,
  parameter int DATA_W   = 32,
  parameter int CC_LSB   = 24,
  parameter int EXC_LSB  = 8,
  parameter int EXC_W    = 8,
  parameter int BSUN_POS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [PRED_W-1:0] predCode,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [EXC_W-1:0]  trapEnable,
  output logic              resultValid,
  output logic              condTrue,
  output logic              illegalPred,
  output logic              trapReq,
  output logic [DATA_W-1:0] statusOut
);
  evalStrobes_t strobes;

  fpc_pred_ctrl #(.PRED_W(PRED_W)) u_ctrl (
    .evalValid (evalValid),
    .predCode  (predCode),
    .strobes   (strobes)
  );

  fpc_pred_datapath #(
    .DATA_W(DATA_W), .CC_LSB(CC_LSB), .EXC_LSB(EXC_LSB),
    .EXC_W(EXC_W), .BSUN_POS(BSUN_POS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .statusIn    (statusIn),
    .trapEnable  (trapEnable),
    .resultValid (resultValid),
    .condTrue    (condTrue),
    .illegalPred (illegalPred),
    .trapReq     (trapReq),
    .statusOut   (statusOut)
  );
endmodule

// File: rtl/fpc_cond_eval_chk.sv
module fpc_cond_eval_chk (
  input logic        clk,
  input logic        rstN,
  input logic        evalValid,
  input logic [5:0]  predCode,
  input logic [31:0] statusIn,
  input logic [7:0]  trapEnable,
  input logic        resultValid,
  input logic        condTrue,
  input logic        illegalPred,
  input logic        trapReq,
  input logic [31:0] statusOut
);
  a_r1_illegal_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && predCode[5]) |=> (illegalPred && !condTrue && !trapReq
                                    && statusOut == $past(statusIn)));

  a_r2_bsun_tracks: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && !predCode[5]) |=> (statusOut[15] == ($past(predCode[4]) && $past(statusIn[24]))));

  a_r5_exc_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && !predCode[5]) |=> (statusOut[14:8] == 7'd0
      && statusOut[31:16] == $past(statusIn[31:16]) && statusOut[7:0] == $past(statusIn[7:0])));

  a_r6_trap_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && !predCode[5]) |=> (trapReq == |(statusOut[15:8] & $past(trapEnable))));

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> resultValid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |=> (!resultValid && $stable(condTrue) && $stable(statusOut)
                    && $stable(trapReq) && $stable(illegalPred)));

  a_r4_false_code: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && predCode[5] == 1'b0 && predCode[3:0] == 4'h0) |=> !condTrue);

  a_r3_true_code: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && predCode[5] == 1'b0 && predCode[3:0] == 4'hF) |=> condTrue);
endmodule

bind fpc_cond_eval fpc_cond_eval_chk u_chk (
  .clk(clk), .rstN(rstN), .evalValid(evalValid), .predCode(predCode),
  .statusIn(statusIn), .trapEnable(trapEnable), .resultValid(resultValid),
  .condTrue(condTrue), .illegalPred(illegalPred), .trapReq(trapReq),
  .statusOut(statusOut)
);

// File: tb/fpc_cond_eval_tb.sv
module fpc_cond_eval_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evalValid = 1'b0;
  logic [5:0] predCode = '0;
  logic [31:0] statusIn = '0;
  logic [7:0] trapEnable = '0;
  logic resultValid, condTrue, illegalPred, trapReq;
  logic [31:0] statusOut;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fpc_cond_eval u_dut (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .predCode(predCode),
    .statusIn(statusIn), .trapEnable(trapEnable), .resultValid(resultValid),
    .condTrue(condTrue), .illegalPred(illegalPred), .trapReq(trapReq),
    .statusOut(statusOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (pred %h status %h)", req, act, exp, predCode, statusIn);
    end
  endtask

  // reference answer built from the relation table (R3, R4)
  function automatic logic refCond(input logic [5:0] p, input logic [3:0] cc);
    logic n, z, u;
    int code;
    logic r;
    n = cc[3]; z = cc[2]; u = cc[0];
    code = p[3] ? (15 - int'(p[3:0])) : int'(p[2:0]);
    case (code)
      0: r = 0;
      1: r = z;
      2: r = !u && !z && !n;
      3: r = z || (!u && !n);
      4: r = n && !u && !z;
      5: r = z || (n && !u);
      6: r = !u && !z;
      default: r = !u;
    endcase
    return p[3] ? !r : r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 valid", 32'(resultValid), 0);
    check("R8 cond", 32'(condTrue), 0);
    check("R8 illegal", 32'(illegalPred), 0);
    check("R8 trap", 32'(trapReq), 0);
    check("R8 status", statusOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 64; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] st, expSt;
        logic [7:0] en;
        logic expBsun, expTrap, expCond, isIll;
        st = {4'(p), 4'(c), 8'(p * 7 + c), 8'(c * 29 + p), 8'(p * 13)};
        en = ((p + c) % 3 == 0) ? 8'hFF : 8'((p * 37 + c * 11) & 8'h7F);
        predCode = 6'(p); statusIn = st; trapEnable = en; evalValid = 1'b1;
        @(negedge clk);
        evalValid = 1'b0;
        isIll = (p >= 32);
        expBsun = !isIll && p[4] && st[24];
        expSt = isIll ? st : {st[31:16], expBsun, 7'd0, st[7:0]};
        expTrap = expBsun && en[7];
        expCond = isIll ? 1'b0 : refCond(6'(p), st[27:24]);
        check("R7 valid", 32'(resultValid), 1);
        check("R1 illegal", 32'(illegalPred), 32'(isIll));
        if (isIll) check("R1 status", statusOut, expSt);
        else if (p[4]) check("R2 status", statusOut, expSt);
        else check("R5 status", statusOut, expSt);
        if (p[3]) check("R3 cond", 32'(condTrue), 32'(expCond));
        else check("R4 cond", 32'(condTrue), 32'(expCond));
        check("R6 trap", 32'(trapReq), 32'(expTrap));
        if (c == 5 && p == 17) begin
          // R7: outputs hold while idle
          statusIn = 32'hFFFF_FFFF; predCode = 6'h3F;
          @(negedge clk);
          check("R7 idle valid", 32'(resultValid), 0);
          check("R7 hold status", statusOut, expSt);
          check("R7 hold cond", 32'(condTrue), 32'(expCond));
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule